// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through a single 32-bit control word. The low field of the word gives a start count, one bit of that field doubles as the run command, and a key field sits directly above it. Once the stored word has its run bit set, the block refuses any rewrite whose key is not the bitwise inverse of the stored key. A stray or repeated write therefore cannot kick the dog by accident.

The counter steps down once per slow tick. The tick comes from an internal prescaler that divides the core clock down to the tick rate. When the count first runs out, the block raises a non-maskable interrupt line and loads a short grace count. If the grace count also runs out before an accepted write, the block emits a one-cycle system reset request. An accepted write lowers the interrupt line and reloads the counter. A write can also stop the counter altogether.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored control word becomes 0, the count becomes 0, the counter stops, and `nmi` and `rst_req` are low.
- R2: While bit CNT_W-1 of the stored control word is 0, every write is accepted, and `ctrl_value` equals the written word one cycle later.
- R3: While bit CNT_W-1 of the stored word is 1, a write is accepted only if its key field (bits CNT_W+KEY_W-1 down to CNT_W) equals the bitwise inverse of the stored key field. A refused write leaves the stored word unchanged.
- R4: On an accepted write, `count_value` loads the low CNT_W bits of the word. A value of zero loads 2^(CNT_W-1) instead.
- R5: An accepted write with bit CNT_W-1 at 1 starts the countdown. With that bit at 0 the count is stopped and holds its value.
- R6: A running count drops by one on each tick. One tick occurs every CLK_HZ/TICK_HZ clock cycles. Starting from a load of N, `nmi` rises between (N-1)*DIV+1 and N*DIV cycles after the write edge.
- R7: After `nmi` rises, the grace count of GRACE_TICKS ticks runs. `rst_req` is then asserted exactly GRACE_TICKS*DIV cycles after the `nmi` rise, and only while `nmi` is high.
- R8: An accepted write lowers `nmi` on the next cycle and restarts the count. No reset request follows from the earlier expiry.
- R9: `rst_req` is a single-cycle pulse. Afterwards `nmi` stays high, the counter is stopped at 0, and no further request is made until an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| ctrl_value | output | 32 | Stored control word |
| count_value | output | CNT_W | Current countdown value |
| nmi | output | 1 | Non-maskable interrupt, high after the first expiry |
| rst_req | output | 1 | One-cycle system reset request after the grace expiry |

## Verification
The bench builds the block with CLK_HZ=4, TICK_HZ=1, CNT_W=4, KEY_W=3 and GRACE_TICKS=1. This gives a four-cycle tick and an 8-value key space. With these values the bench can sweep every stored key against every offered key. It can also run every start count that has the run bit set through the full chain of expiry, grace and reset request, checking each one against an arithmetic window. The same small widths put the zero-load substitute, stopped holds, a rescue during the grace period and a reset during a run within a few hundred cycles.

// File: rtl/kwd_pkg.sv
// Package: shared types and elaboration helpers for the keyed watchdog.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package kwd_pkg;

    // Countdown phase: stopped, first countdown, or grace countdown after the NMI.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_GRACE = 2'd2
    } wd_stage_e;

    // Core clock cycles per watchdog tick. Never below one.
    function automatic int unsigned tick_divisor(input int unsigned clk_hz,
                                                 input int unsigned tick_hz);
        if (tick_hz == 0 || clk_hz <= tick_hz)
            return 1;
        return clk_hz / tick_hz;
    endfunction

endpackage

// File: rtl/kwd_tick_gen.sv
// Module: kwd_tick_gen
// Divides the core clock into a one-cycle tick strobe every CLK_HZ/TICK_HZ cycles.
// Assumes: the prescaler runs freely from reset and is never reloaded by writes,
// and the division ratio is at least 2 (or exactly 1, which ticks every cycle).
module kwd_tick_gen #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_HZ = 760
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV = kwd_pkg::tick_divisor(CLK_HZ, TICK_HZ);
    localparam int          PW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [PW-1:0] pre_cnt;

            // Free-running modulo-DIV counter.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pre_cnt <= '0;
                else if (pre_cnt == PW'(DIV - 1))
                    pre_cnt <= '0;
                else
                    pre_cnt <= pre_cnt + 1'b1;
            end

            assign tick = (pre_cnt == PW'(DIV - 1));
        end else begin : g_nodiv
            logic tick_q;

            // Divide-by-one: tick on every cycle out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tick_q <= 1'b0;
                else
                    tick_q <= 1'b1;
            end

            assign tick = tick_q;
        end
    endgenerate
endmodule

// File: rtl/kwd_key_gate.sv
// Module: kwd_key_gate
// Holds the stored control word and decides whether a write is accepted.
// Assumes: the run bit is bit CNT_W-1 and the key sits right above the count
// field. CNT_W+KEY_W must not exceed 32.
module kwd_key_gate #(
    parameter int CNT_W = 9,
    parameter int KEY_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        accept,
    output logic [31:0] ctrl_q
);
    localparam int RUN_BIT = CNT_W - 1;
    localparam int KEY_LO  = CNT_W;
    localparam int KEY_HI  = CNT_W + KEY_W - 1;

    logic [KEY_W-1:0] offered_key;
    logic [KEY_W-1:0] held_key;
    logic             key_match;

    // Compare the offered key with the inverse of the held key.
    always_comb begin
        offered_key = wr_data[KEY_HI:KEY_LO];
        held_key    = ctrl_q[KEY_HI:KEY_LO];
        key_match   = (offered_key == ~held_key);
        accept      = wr_en && (!ctrl_q[RUN_BIT] || key_match);
    end

    // Latch the whole written word when the write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (accept)
            ctrl_q <= wr_data;
    end
endmodule

// File: rtl/kwd_stage_ctr.sv
// Module: kwd_stage_ctr
// Two-phase countdown: the first expiry raises the NMI and loads the grace count,
// and the grace expiry pulses the reset request.
// Assumes: a load takes priority over a tick in the same cycle, and
// GRACE_TICKS lies between 1 and 2^CNT_W-1.
module kwd_stage_ctr #(
    parameter int CNT_W       = 9,
    parameter int GRACE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_field,
    input  logic             load_run,
    output logic [CNT_W-1:0] count,
    output logic             nmi,
    output logic             rst_req
);
    import kwd_pkg::*;

    localparam logic [CNT_W-1:0] ZERO_LOAD  = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_TICKS);

    wd_stage_e        stage;
    logic [CNT_W-1:0] load_val;

    // Substitute the half-range value for a zero count field.
    always_comb begin
        load_val = (load_field == '0) ? ZERO_LOAD : load_field;
    end

    // Countdown, phase change, NMI flag and one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage   <= ST_IDLE;
            count   <= '0;
            nmi     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (load) begin
                count <= load_val;
                stage <= load_run ? ST_ARMED : ST_IDLE;
                nmi   <= 1'b0;
            end else if (tick && stage != ST_IDLE) begin
                if (count > CNT_W'(1)) begin
                    count <= count - 1'b1;
                end else if (stage == ST_ARMED) begin
                    stage <= ST_GRACE;
                    count <= GRACE_LOAD;
                    nmi   <= 1'b1;
                end else begin
                    stage   <= ST_IDLE;
                    count   <= '0;
                    rst_req <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed_watchdog (top)
// Keyed watchdog with an NMI stage followed by a reset request.
// Assumes: writes are single-cycle strobes in the core clock domain.
module keyed_watchdog #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TICK_HZ     = 760,
    parameter int          CNT_W       = 9,
    parameter int          KEY_W       = 7,
    parameter int          GRACE_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      ctrl_value,
    output logic [CNT_W-1:0] count_value,
    output logic             nmi,
    output logic             rst_req
);
    logic tick;
    logic accept;

    kwd_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kwd_key_gate #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .accept  (accept),
        .ctrl_q  (ctrl_value)
    );

    kwd_stage_ctr #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (accept),
        .load_field (wr_data[CNT_W-1:0]),
        .load_run   (wr_data[CNT_W-1]),
        .count      (count_value),
        .nmi        (nmi),
        .rst_req    (rst_req)
    );
endmodule

// File: rtl/kwd_checker.sv
// Module: kwd_checker
// Temporal checks on the keyed watchdog ports, attached by bind.
// Assumes: the same CNT_W and KEY_W as the bound instance.
module kwd_checker #(
    parameter int CNT_W = 9,
    parameter int KEY_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      ctrl_value,
    input logic [CNT_W-1:0] count_value,
    input logic             nmi,
    input logic             rst_req
);
    localparam int RUN_BIT = CNT_W - 1;
    localparam int KEY_LO  = CNT_W;
    localparam int KEY_HI  = CNT_W + KEY_W - 1;

    logic key_ok;
    logic wr_ok;

    // Acceptance as seen from the ports.
    always_comb begin
        key_ok = (wr_data[KEY_HI:KEY_LO] == ~ctrl_value[KEY_HI:KEY_LO]);
        wr_ok  = wr_en && (!ctrl_value[RUN_BIT] || key_ok);
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ctrl_value == '0 && count_value == '0 && !nmi && !rst_req));

    a_r2_open_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_value[RUN_BIT]) |=> (ctrl_value == $past(wr_data)));

    a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_value[RUN_BIT] && !key_ok) |=> $stable(ctrl_value));

    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ctrl_value[RUN_BIT]) |=> $stable(count_value));

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count_value == $past(count_value)
                    || count_value == $past(count_value) - 1'b1
                    || $rose(nmi) || count_value == '0));

    a_r7_nmi_precedes_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> nmi);

    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (!nmi && !rst_req));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_kwd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ctrl_value  (ctrl_value),
    .count_value (count_value),
    .nmi         (nmi),
    .rst_req     (rst_req)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int CLK_HZ = 4;
    localparam int TICK_HZ = 1;
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int CW = 4;
    localparam int KW = 3;
    localparam int GRACE = 1;
    localparam int KMASK = (1 << KW) - 1;
    localparam int CMASK = (1 << CW) - 1;
    localparam int RUNB = CW - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic [31:0]   ctrl_value;
    logic [CW-1:0] count_value;
    logic          nmi;
    logic          rst_req;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [31:0] exp_ctrl;

    always #10 clk = ~clk;

    keyed_watchdog #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(CW), .KEY_W(KW), .GRACE_TICKS(GRACE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_value(ctrl_value), .count_value(count_value), .nmi(nmi), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    function automatic logic [31:0] mk(input int key, input int cnt);
        return 32'(((key & KMASK) << CW) | (cnt & CMASK));
    endfunction

    function automatic int good_key();
        if (exp_ctrl[RUNB])
            return (~int'((exp_ctrl >> CW) & KMASK)) & KMASK;
        return 3;
    endfunction

    // Drive one write strobe; the bench decides acceptance on its own.
    task automatic do_write(input logic [31:0] d);
        bit acc;
        int old_k;
        int new_k;
        old_k = int'((exp_ctrl >> CW) & KMASK);
        new_k = int'((d >> CW) & KMASK);
        acc = !exp_ctrl[RUNB] || (new_k == ((~old_k) & KMASK));
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (acc) exp_ctrl = d;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int d;
        int g;
        int extra;
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
        exp_ctrl = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ctrl_value == 0, "R1 ctrl", int'(ctrl_value), 0);
        check(count_value == 0, "R1 count", int'(count_value), 0);
        check(!nmi, "R1 nmi", int'(nmi), 0);
        check(!rst_req, "R1 rst_req", int'(rst_req), 0);
        rst_n = 1'b1;

        // R2 / R4: zero count field loads half range, stopped
        do_write(mk(5, 0));
        check(ctrl_value == mk(5, 0), "R2 open write", int'(ctrl_value), int'(mk(5, 0)));
        check(count_value == (1 << (CW - 1)), "R4 zero load", int'(count_value), 1 << (CW - 1));
        repeat (3 * DIV) @(negedge clk);
        check(count_value == (1 << (CW - 1)), "R5 stopped hold", int'(count_value), 1 << (CW - 1));
        check(!nmi, "R5 no nmi when stopped", int'(nmi), 0);

        do_write(mk(6, 5));
        check(count_value == 5, "R4 direct load", int'(count_value), 5);
        repeat (3 * DIV) @(negedge clk);
        check(count_value == 5, "R5 stopped hold", int'(count_value), 5);

        // R3: every stored key against every offered key
        for (int k = 0; k <= KMASK; k++) begin
            do_write(mk(k, 9));
            check(ctrl_value == mk(k, 9), "R2 arm", int'(ctrl_value), int'(mk(k, 9)));
            for (int j = 0; j <= KMASK; j++) begin
                if (j != ((~k) & KMASK)) begin
                    do_write(mk(j, 10));
                    check(ctrl_value == mk(k, 9), "R3 bad key ignored",
                          int'(ctrl_value), int'(mk(k, 9)));
                end
            end
            do_write(mk(~k, 0));
            check(ctrl_value == mk(~k, 0), "R3 inverse key accepted",
                  int'(ctrl_value), int'(mk(~k, 0)));
            check(count_value == (1 << (CW - 1)), "R4 reload", int'(count_value), 1 << (CW - 1));
        end

        // R6/R7/R9 sweep over every start count with the run bit set
        for (int n = (1 << RUNB); n <= CMASK; n++) begin
            do_write(mk(good_key(), n));
            if (n > (1 << RUNB))
                check(!nmi, "R8 write lowers nmi", int'(nmi), 0);
            check(count_value == n, "R4 run load", int'(count_value), n);
            d = 1;
            while (!nmi && d < 300) begin
                @(negedge clk);
                d++;
            end
            check(d >= (n - 1) * DIV + 1 && d <= n * DIV, "R6 expiry window", d, n * DIV);
            g = 0;
            while (!rst_req && g < 300) begin
                @(negedge clk);
                g++;
            end
            check(g == GRACE * DIV, "R7 grace delay", g, GRACE * DIV);
            @(negedge clk);
            check(!rst_req, "R9 single pulse", int'(rst_req), 0);
            check(nmi, "R9 nmi held", int'(nmi), 1);
            extra = 0;
            repeat (3 * DIV) begin
                @(negedge clk);
                if (rst_req) extra++;
            end
            check(extra == 0, "R9 no repeat request", extra, 0);
            check(count_value == 0, "R9 stopped at zero", int'(count_value), 0);
        end

        // R8: rescue inside the grace window
        do_write(mk(good_key(), 10));
        d = 1;
        while (!nmi && d < 300) begin
            @(negedge clk);
            d++;
        end
        check(nmi, "R6 nmi reached", int'(nmi), 1);
        do_write(mk(good_key(), 12));
        check(!nmi, "R8 rescue lowers nmi", int'(nmi), 0);
        extra = 0;
        repeat (4 * DIV) begin
            @(negedge clk);
            if (rst_req || nmi) extra++;
        end
        check(extra == 0, "R8 no reset after rescue", extra, 0);
        check(count_value < 12 && count_value > 0, "R6 counting down", int'(count_value), 8);

        // R1: reset during a run
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ctrl_value == 0, "R1 ctrl after run", int'(ctrl_value), 0);
        check(count_value == 0, "R1 count after run", int'(count_value), 0);
        check(!nmi && !rst_req, "R1 outputs after run", int'(nmi), 0);
        rst_n = 1'b1;
        exp_ctrl = '0;
        do_write(mk(1, 9));
        check(ctrl_value == mk(1, 9), "R2 open after reset", int'(ctrl_value), int'(mk(1, 9)));

        done = 1;
        summary();
        $finish;
    end
endmodule